// File: doc/BRIEF.md
# Serial Control Write Port

This block is the host-facing control port of an audio signal processor. An external microcontroller drives three lines into it: an active-low select, a serial clock and a serial data line. While select is low, each rising edge of the serial clock shifts one data bit into the port. A complete frame is 40 bits, sent most significant bit first, as an 8-bit command, a 16-bit address and a 16-bit data word. When the last bit arrives, the port presents the frame on a parallel write interface as a one-cycle strobe. The strobe carries the command, the address, the data and a decoded target memory.

The command decides how the frame is handled. Plain register writes go out at once. Sample-synchronous register writes and memory writes are paced, because the processor core takes at most one such word per audio sample period. After a paced write the port raises `busy`. It holds `busy` until the sample-rate tick `fs_tick` has pulsed a set number of times, and it rejects every frame that arrives in that window. A dedicated master-reset command with only data bit 15 set produces a one-cycle `soft_rst` pulse instead of a write.

The three serial inputs are asynchronous to `clk` and are resynchronised inside the port. `fs_tick` is a single-cycle pulse in the `clk` domain.

Top module: `ctl_serial_port`

## Requirements
- R1: While `cs_n` is low, `sdi` is sampled on each rising edge of `sck`. The 40 bits form {cmd[7:0], addr[15:0], data[15:0]}, sent first bit first. After the 40th bit, `wr_valid` pulses for one cycle, with the fields on `wr_cmd`, `wr_addr` and `wr_data`.
- R2: While `cs_n` is high, activity on `sck` and `sdi` neither produces a strobe nor alters the next frame.
- R3: Bits clocked after the 40th while `cs_n` stays low are ignored. Exactly one strobe is produced per select-low period.
- R4: If `cs_n` rises before 40 bits have arrived, the partial frame is discarded. A following full frame is decoded correctly.
- R5: Commands with bit 7 or bit 6 set are paced. Accepting one sets `busy`, and `busy` falls on the edge that samples the PACE_TICKS-th `fs_tick` pulse after acceptance. The default for PACE_TICKS is 2.
- R6: A frame that completes while `busy` is high produces no strobe and leaves `busy` high.
- R7: Command 3Fh with data 8000h pulses `soft_rst` for one cycle. It produces no `wr_valid` and clears `busy`, and it is honoured even while `busy` is high.
- R8: Command 3Fh with any other data produces neither `soft_rst` nor `wr_valid`.
- R9: `wr_target` is 0 (register) when cmd bit 7 is 0. Otherwise it is 4 + cmd[1:0], where 4 is coefficient, 5 is offset, 6 is sequence and 7 is delay memory.
- R10: Commands with bits 7 and 6 both clear, other than 3Fh, are written immediately and leave `busy` low.
- R11: After reset, `wr_valid`, `soft_rst` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from host |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| fs_tick | input | 1 | One-cycle pulse per audio sample period |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_cmd | output | 8 | Command field of the accepted frame |
| wr_addr | output | 16 | Address field of the accepted frame |
| wr_data | output | 16 | Data field of the accepted frame |
| wr_target | output | 3 | Decoded destination memory |
| soft_rst | output | 1 | One-cycle master-reset pulse |
| busy | output | 1 | Pacing window active, frames rejected |

## Verification
The strobe, `soft_rst` and the setting of `busy` all follow the last `sck` rising edge by four `clk` cycles. Two cycles go to the synchroniser, one to the shift register and one to the output register. The bench therefore drives `sck` at a slow, even rate and waits a fixed settle time after each frame before it reads anything. A monitor sampling on the falling clock edge counts the strobes and reset pulses, so a missing or extra pulse is caught regardless of its cycle. `busy` is read one falling edge after each `fs_tick` pulse, since it clears on the edge that samples the tick.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

    localparam int CMD_W   = 8;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [2:0] {
        TGT_REG  = 3'd0,
        TGT_COEF = 3'd4,
        TGT_OFFS = 3'd5,
        TGT_MSEQ = 3'd6,
        TGT_DLY  = 3'd7
    } target_t;

    localparam logic [CMD_W-1:0]  MRST_CMD  = {2'b00, {(CMD_W-2){1'b1}}};
    localparam logic [DATA_W-1:0] MRST_DATA = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic is_paced(input logic [CMD_W-1:0] cmd);
        return cmd[CMD_W-1] | cmd[CMD_W-2];
    endfunction

    function automatic target_t decode_target(input logic [CMD_W-1:0] cmd);
        return cmd[CMD_W-1] ? target_t'({1'b1, cmd[1:0]}) : TGT_REG;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1 <= RST_VAL[i];
                st2 <= RST_VAL[i];
            end else begin
                st1 <= din[i];
                st2 <= st1;
            end
        end
        assign dout[i] = st2;
    end
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter
    import ctl_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sck,
    input  logic   sdi,
    output logic   frame_valid,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic               sck_q;
    logic               sck_rise;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;

    assign sck_rise = sck & ~sck_q;
    assign frame    = frame_t'(sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q       <= 1'b0;
            cnt         <= '0;
            sh          <= '0;
            frame_valid <= 1'b0;
        end else begin
            sck_q       <= sck;
            frame_valid <= 1'b0;
            if (cs_n) begin
                cnt <= '0;
                sh  <= '0;
            end else if (sck_rise && cnt != FULL) begin
                sh  <= {sh[FRAME_W-2:0], sdi};
                cnt <= cnt + 1'b1;
                if (cnt == LAST) frame_valid <= 1'b1;
            end
        end
    end

    AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cnt == '0) && !frame_valid); // R4
    AST_FRAME_FULL: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (cnt == FULL)); // R3

endmodule

// File: rtl/ctl_pacer.sv
module ctl_pacer #(
    parameter int PACE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clear,
    input  logic fs_tick,
    output logic busy
);
    localparam int TW = $clog2(PACE_TICKS + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(PACE_TICKS - 1);

    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy  <= 1'b0;
            ticks <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ticks <= '0;
        end else if (busy && fs_tick) begin
            if (ticks == LAST_TICK) begin
                busy  <= 1'b0;
                ticks <= '0;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy && !fs_tick && !clear |=> busy); // R5
    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        start && !clear |=> busy); // R5

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int PACE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              fs_tick,
    output logic              wr_valid,
    output logic [CMD_W-1:0]  wr_cmd,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [2:0]        wr_target,
    output logic              soft_rst,
    output logic              busy
);
    logic [2:0] pins_s;
    logic       frame_valid;
    frame_t     frame;
    logic       is_mrst;
    logic       accept;
    logic       do_rst;

    ctl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sck, sdi}),
        .dout (pins_s)
    );

    ctl_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (pins_s[2]),
        .sck         (pins_s[1]),
        .sdi         (pins_s[0]),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    always_comb begin
        is_mrst = (frame.cmd == MRST_CMD);
        accept  = frame_valid && !busy && !is_mrst;
        do_rst  = frame_valid && is_mrst && (frame.data == MRST_DATA);
    end

    ctl_pacer #(.PACE_TICKS(PACE_TICKS)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .start   (accept && is_paced(frame.cmd)),
        .clear   (do_rst),
        .fs_tick (fs_tick),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid  <= 1'b0;
            soft_rst  <= 1'b0;
            wr_cmd    <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_target <= '0;
        end else begin
            wr_valid <= accept;
            soft_rst <= do_rst;
            if (accept) begin
                wr_cmd    <= frame.cmd;
                wr_addr   <= frame.addr;
                wr_data   <= frame.data;
                wr_target <= decode_target(frame.cmd);
            end
        end
    end

    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (rst)
        frame_valid && busy |=> !wr_valid); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, soft_rst})); // R7
    AST_PACED_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_valid && is_paced(wr_cmd) |-> busy); // R5
    AST_RST_FREES: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> !busy); // R7

endmodule

// File: tb/ctl_serial_port_tb.sv
module ctl_serial_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, fs_tick = 1'b0;
    logic        wr_valid, soft_rst, busy;
    logic [7:0]  wr_cmd;
    logic [15:0] wr_addr, wr_data;
    logic [2:0]  wr_target;

    int errs = 0, checks = 0;
    int n_wr = 0, n_rst = 0;
    logic [7:0]  cap_cmd;
    logic [15:0] cap_addr, cap_data;
    logic [2:0]  cap_tgt;

    always #4 clk = ~clk;

    ctl_serial_port u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .fs_tick(fs_tick), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_target(wr_target),
        .soft_rst(soft_rst), .busy(busy)
    );

    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            n_wr++;
            cap_cmd  = wr_cmd;
            cap_addr = wr_addr;
            cap_data = wr_data;
            cap_tgt  = wr_target;
        end
        if (!rst && soft_rst) n_rst++;
    end

    // {cmd, addr, data, expect write, expect soft reset}
    localparam logic [41:0] VEC [6] = '{
        {8'h00, 16'h0000, 16'h0000, 1'b1, 1'b0},
        {8'h12, 16'hA5C3, 16'h5A3C, 1'b1, 1'b0},
        {8'h3E, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0},
        {8'h01, 16'h8001, 16'h7FFE, 1'b1, 1'b0},
        {8'h3F, 16'h0000, 16'h8001, 1'b0, 1'b0},
        {8'h3F, 16'h1234, 16'h8000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [39:0] f, input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 40) ? f[39 - i] : 1'b1;
            sck = 1'b0;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) fs_tick = 1'b1;
        @(negedge clk) fs_tick = 1'b0;
    endtask

    task automatic chk_frame(input string req, input logic [39:0] f);
        chk(req, {cap_cmd, cap_addr, cap_data}, f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        int w0, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 wr_valid", wr_valid, 0);
        chk("R11 soft_rst", soft_rst, 0);
        chk("R11 busy", busy, 0);

        // Table: R1, R7, R8, R10
        for (int v = 0; v < 6; v++) begin
            w0 = n_wr; r0 = n_rst;
            send(VEC[v][41:2], 40);
            chk("R1/R8 write count", n_wr - w0, VEC[v][1]);
            chk("R7/R8 reset count", n_rst - r0, VEC[v][0]);
            if (VEC[v][1]) begin
                chk_frame("R1 fields", VEC[v][41:2]);
                chk("R9 target reg", cap_tgt, 0);
            end
            chk("R10 busy low", busy, 0);
        end

        // R2: clocking with select high is ignored
        w0 = n_wr;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) begin sdi = i[0]; sck = 1'b1; end
            repeat (3) @(negedge clk);
            sck = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk("R2 no strobe", n_wr - w0, 0);
        send({8'h05, 16'h1357, 16'h2468}, 40);
        chk("R2 next frame clean", n_wr - w0, 1);
        chk_frame("R2 fields", {8'h05, 16'h1357, 16'h2468});

        // R4: aborted partial frame
        w0 = n_wr;
        send({8'hFF, 16'hFFFF, 16'hFFFF}, 20);
        chk("R4 no strobe on abort", n_wr - w0, 0);
        send({8'h09, 16'h00F0, 16'h0F00}, 40);
        chk("R4 one strobe", n_wr - w0, 1);
        chk_frame("R4 fields", {8'h09, 16'h00F0, 16'h0F00});

        // R3: extra bits ignored
        w0 = n_wr;
        send({8'h22, 16'hC0DE, 16'h0BEE}, 44);
        chk("R3 one strobe", n_wr - w0, 1);
        chk_frame("R3 fields", {8'h22, 16'hC0DE, 16'h0BEE});

        // R5, R6, R9: pacing
        w0 = n_wr;
        send({8'h81, 16'h0010, 16'h1111}, 40);
        chk("R5 paced write", n_wr - w0, 1);
        chk("R9 target offset", cap_tgt, 5);
        chk("R5 busy set", busy, 1);
        send({8'h82, 16'h0011, 16'h2222}, 40);
        chk("R6 rejected", n_wr - w0, 1);
        chk("R6 busy kept", busy, 1);
        tick();
        chk("R5 busy after 1 tick", busy, 1);
        tick();
        chk("R5 busy after 2 ticks", busy, 0);
        send({8'h82, 16'h0011, 16'h2222}, 40);
        chk("R5 accepted after window", n_wr - w0, 2);
        chk("R9 target sequence", cap_tgt, 6);
        tick(); tick();
        send({8'h40, 16'h0042, 16'h3333}, 40);
        chk("R5 sync reg write", n_wr - w0, 3);
        chk("R9 target reg for sync", cap_tgt, 0);
        chk("R5 sync busy", busy, 1);

        // R7: master reset while busy
        r0 = n_rst;
        send({8'h3F, 16'h0000, 16'h8000}, 40);
        chk("R7 reset pulse", n_rst - r0, 1);
        chk("R7 no write", n_wr - w0, 3);
        chk("R7 busy cleared", busy, 0);

        send({8'h83, 16'h07FF, 16'h4444}, 40);
        chk("R9 target delay", cap_tgt, 7);
        chk_frame("R1 paced fields", {8'h83, 16'h07FF, 16'h4444});

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule